// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a three-wire serial link to an EEPROM that holds 64 words of 16 bits. A parallel command port takes an operation, a 6-bit word address and 16 bits of write data. The controller then produces the chip select, the serial clock and the serial data-in waveforms for that instruction. It samples the serial data-out line and reports completion with a one-cycle done pulse. Read data is returned in parallel.

The serial clock is made by dividing the system clock. Each half period of the serial clock lasts `HALF_DIV` system clocks, so one parameter meets the 1 MHz limit, the 500 ns minimum high and low phases, and the setup and hold windows for chip select and data-in. Commands that change the array do not complete when their frame ends. The controller first drops chip select for one half period and raises it again. It then watches data-out until the device reports ready. A poll that runs past `POLL_MAX` half periods ends the command with an error flag.

Top module: `mw_eeprom_host`

## Requirements
- R1: While reset is held, and on release, `ee_cs`, `ee_sk`, `ee_di` and `rsp_done` are low and `cmd_ready` is high.
- R2: Every high phase of `ee_sk` lasts exactly `HALF_DIV` system clocks. Every low phase of `ee_sk` that precedes a rising edge inside a frame also lasts exactly `HALF_DIV` system clocks. `ee_sk` is high only while `ee_cs` is high.
- R3: A frame starts with a 1, then two opcode bits, then six address bits, all MSB first. The `cmd_op` codes are 0 read (opcode 10), 1 write (01), 2 erase (11), 3 write-enable (00 with address 11xxxx), 4 write-disable (00 with 00xxxx), 5 erase-all (00 with 10xxxx) and 6 write-all (00 with 01xxxx). Code 7 behaves as write-disable, and every don't-care address slot is sent as 0.
- R4: A read is 25 serial clocks. `ee_do` is sampled in the last system clock of the high phase of clocks 10 to 25, and the bits are assembled MSB first into `rsp_rdata`. `rsp_rdata` is valid with `rsp_done` and holds until the next read.
- R5: Write and write-all send the 16 data bits MSB first after the address, for 25 clocks. Erase, erase-all, write-enable and write-disable use 9 clocks.
- R6: `ee_di` changes only when a low phase of `ee_sk` begins or when the frame starts. It is stable for the whole of each high phase and is 0 whenever no frame bit is being sent, including the data slots of a read and every cycle with `ee_cs` low.
- R7: Between any two high periods of `ee_cs`, the signal stays low for at least `HALF_DIV` system clocks. `ee_cs` is low when `rsp_done` pulses.
- R8: For write, erase, erase-all and write-all, chip select is dropped for one half period after the frame and then raised again. `ee_do` is then sampled at the end of each half period, where 0 means busy and 1 means ready. On ready, chip select falls and the command completes with `rsp_err` low.
- R9: If `ee_do` has not read high after `POLL_MAX` poll samples, the command completes with `rsp_err` high. `rsp_err` holds until the next command is accepted.
- R10: `cmd_ready` is high only when no command is in progress. A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both high. `rsp_done` is a single-cycle pulse, and `cmd_ready` is high again from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command can be accepted |
| cmd_op | input | 3 | Operation code (see R3) |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Data for write and write-all |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Data from the last read |
| rsp_err | output | 1 | Ready poll timed out |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data and ready/busy status from the EEPROM |

## Verification
Some rules are checked by the assertions on every cycle:
- the serial clock appears only under chip select;
- data-in is quiet with chip select low and stable through each high phase;
- chip select stays low past its falling edge;
- done is a single pulse, and the port is ready only when idle;
- the divider, bit index and poll counters stay within their bounds.

Other behaviour only the bench's scenarios can show. This includes the exact half-period lengths, the bit order and clock count of each frame, and read data assembled from a device model. It also includes the extra chip-select rise for polling, completion only after the model leaves busy, and the timeout error against a device that stays busy.

// File: rtl/mw_pkg.sv
package mw_pkg;

  localparam int FRAME_MAX = 25;
  localparam int HDR_BITS  = 9;
  localparam int IDX_W     = 5;

  localparam logic [2:0] OP_READ    = 3'd0;
  localparam logic [2:0] OP_WRITE   = 3'd1;
  localparam logic [2:0] OP_ERASE   = 3'd2;
  localparam logic [2:0] OP_WEN     = 3'd3;
  localparam logic [2:0] OP_WDIS    = 3'd4;
  localparam logic [2:0] OP_CLRALL  = 3'd5;
  localparam logic [2:0] OP_FILLALL = 3'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_HI, S_LO, S_TAIL, S_BREAK, S_POLL, S_GAP
  } mw_state_e;

  // Left-aligned serial image: start, opcode, address, data slots.
  function automatic logic [FRAME_MAX-1:0] frame_bits(input logic [2:0] op,
                                                      input logic [5:0] addr,
                                                      input logic [15:0] data);
    logic [1:0]  opc;
    logic [5:0]  a;
    logic [15:0] d;
    d = '0;
    a = addr;
    case (op)
      OP_READ:    opc = 2'b10;
      OP_WRITE:   begin opc = 2'b01; d = data; end
      OP_ERASE:   opc = 2'b11;
      OP_WEN:     begin opc = 2'b00; a = 6'b110000; end
      OP_CLRALL:  begin opc = 2'b00; a = 6'b100000; end
      OP_FILLALL: begin opc = 2'b00; a = 6'b010000; d = data; end
      default:    begin opc = 2'b00; a = 6'b000000; end
    endcase
    return {1'b1, opc, a, d};
  endfunction

  function automatic logic [IDX_W-1:0] frame_len(input logic [2:0] op);
    if (op == OP_READ || op == OP_WRITE || op == OP_FILLALL)
      return IDX_W'(FRAME_MAX);
    return IDX_W'(HDR_BITS);
  endfunction

  function automatic logic needs_poll(input logic [2:0] op);
    return (op == OP_WRITE) || (op == OP_ERASE) ||
           (op == OP_CLRALL) || (op == OP_FILLALL);
  endfunction

endpackage

// File: rtl/mw_phase_div.sv
module mw_phase_div #(
  parameter int HALF_DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_div_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/mw_frame_unit.sv
module mw_frame_unit
  import mw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [2:0]  op,
  input  logic [5:0]  addr,
  input  logic [15:0] wdata,
  input  logic        advance,
  input  logic        capture,
  input  logic        do_in,
  output logic        cur_bit,
  output logic        last_bit,
  output logic [15:0] rdata
);
  logic [FRAME_MAX-1:0] frame_q;
  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W-1:0]     len_q;
  logic                 rd_q;
  logic [15:0]          rdata_q;
  logic                 data_slot;

  assign data_slot = rd_q && (idx_q >= IDX_W'(HDR_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      idx_q   <= '0;
      len_q   <= IDX_W'(HDR_BITS);
      rd_q    <= 1'b0;
      rdata_q <= '0;
    end else if (load) begin
      frame_q <= frame_bits(op, addr, wdata);
      len_q   <= frame_len(op);
      idx_q   <= '0;
      rd_q    <= (op == OP_READ);
    end else begin
      if (capture && data_slot) rdata_q <= {rdata_q[14:0], do_in};
      if (advance) begin
        frame_q <= {frame_q[FRAME_MAX-2:0], 1'b0};
        idx_q   <= idx_q + 1'b1;
      end
    end
  end

  assign cur_bit  = frame_q[FRAME_MAX-1];
  assign last_bit = (idx_q == len_q - 1'b1);
  assign rdata    = rdata_q;

  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < len_q);
  p_no_step_past_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !last_bit);

endmodule

// File: rtl/mw_poll_timer.sv
module mw_poll_timer #(
  parameter int POLL_MAX = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic at_limit
);
  localparam int TW = $clog2(POLL_MAX + 1);
  localparam logic [TW-1:0] LIM = TW'(POLL_MAX - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clear)                 cnt_q <= '0;
    else if (step && cnt_q != LIM)  cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit = (cnt_q == LIM);

  p_poll_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
  import mw_pkg::*;
#(
  parameter int HALF_DIV = 125,
  parameter int POLL_MAX = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_op,
  input  logic [5:0]  cmd_addr,
  input  logic [15:0] cmd_wdata,
  output logic        rsp_done,
  output logic [15:0] rsp_rdata,
  output logic        rsp_err,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);
  mw_state_e state_q;
  logic      poll_q, err_q, done_q;

  // named events
  logic tick, accept, hi_end, poll_ready, poll_expire, cur_bit, last_bit;

  assign accept      = cmd_valid && cmd_ready;
  assign hi_end      = tick && (state_q == S_HI);
  assign poll_ready  = tick && (state_q == S_POLL) && ee_do;
  logic  poll_limit;
  assign poll_expire = tick && (state_q == S_POLL) && !ee_do && poll_limit;

  mw_phase_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(state_q != S_IDLE), .tick(tick));

  mw_frame_unit u_frame (
    .clk(clk), .rst_n(rst_n), .load(accept), .op(cmd_op), .addr(cmd_addr),
    .wdata(cmd_wdata), .advance(hi_end && !last_bit), .capture(hi_end),
    .do_in(ee_do), .cur_bit(cur_bit), .last_bit(last_bit), .rdata(rsp_rdata));

  mw_poll_timer #(.POLL_MAX(POLL_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(state_q != S_POLL),
    .step(tick && state_q == S_POLL), .at_limit(poll_limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      poll_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= tick && (state_q == S_GAP);
      if (accept) begin
        state_q <= S_SETUP;
        poll_q  <= needs_poll(cmd_op);
        err_q   <= 1'b0;
      end else if (tick) begin
        case (state_q)
          S_SETUP: state_q <= S_HI;
          S_HI:    state_q <= last_bit ? S_TAIL : S_LO;
          S_LO:    state_q <= S_HI;
          S_TAIL:  state_q <= poll_q ? S_BREAK : S_GAP;
          S_BREAK: state_q <= S_POLL;
          S_POLL: begin
            if (poll_ready) state_q <= S_GAP;
            else if (poll_expire) begin
              state_q <= S_GAP;
              err_q   <= 1'b1;
            end
          end
          S_GAP:   state_q <= S_IDLE;
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  logic sending;
  assign sending   = (state_q == S_SETUP) || (state_q == S_HI) || (state_q == S_LO);
  assign ee_cs     = sending || (state_q == S_TAIL) || (state_q == S_POLL);
  assign ee_sk     = (state_q == S_HI);
  assign ee_di     = sending && cur_bit;
  assign cmd_ready = (state_q == S_IDLE);
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;

  p_sk_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);
  p_di_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_di);
  p_di_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |=> !ee_cs);
  p_done_cs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !ee_cs);
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!ee_cs && !ee_sk));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_err_from_poll_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_err) |-> $past(state_q == S_POLL));

endmodule

// File: tb/mw_eeprom_host_tb.sv
`timescale 1ns/1ps
module mw_eeprom_host_tb;
  localparam int HALF = 4;
  localparam int PMAX = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [5:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic cmd_ready, rsp_done, rsp_err, ee_cs, ee_sk, ee_di;
  logic [15:0] rsp_rdata;
  logic ee_do;

  always #2 clk = ~clk;

  mw_eeprom_host #(.HALF_DIV(HALF), .POLL_MAX(PMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [15:0] mdl_mem [64];
  logic        mdl_ew = 1'b0;
  logic [24:0] mdl_sh = '0;
  int          mdl_bits = 0, mdl_last_len = 0, mdl_bad_start = 0;
  int          busy_cnt = 0, busy_len = 20;
  logic        mdl_rd = 1'b0;
  logic [5:0]  mdl_raddr = '0;
  logic        do_q = 1'b1, sk_q = 1'b0, cs_q = 1'b0;
  assign ee_do = do_q;

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 16'h0131) ^ 16'h5A5A;
  endfunction

  initial for (int i = 0; i < 64; i++) mdl_mem[i] = init_word(i);

  always @(posedge clk) begin : model
    logic [24:0] nsh;
    logic [8:0]  head;
    logic [15:0] dat;
    sk_q <= ee_sk;
    cs_q <= ee_cs;
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    do_q <= (busy_cnt > 0) ? 1'b0 : 1'b1;
    if (ee_cs && ee_sk && !sk_q) begin
      nsh = {mdl_sh[23:0], ee_di};
      mdl_sh <= nsh;
      if (mdl_bits == 8) begin
        mdl_rd    <= (nsh[7:6] == 2'b10);
        mdl_raddr <= nsh[5:0];
      end
      mdl_bits <= mdl_bits + 1;
    end
    if (mdl_rd) begin
      if (ee_cs && ee_sk && !sk_q && mdl_bits >= 9)
        do_q <= mdl_mem[mdl_raddr][24 - mdl_bits];
      else
        do_q <= do_q;
    end
    if (cs_q && !ee_cs) begin
      mdl_rd   <= 1'b0;
      mdl_bits <= 0;
      if (mdl_bits >= 9) begin
        mdl_last_len <= mdl_bits;
        if (mdl_bits == 25) begin head = mdl_sh[24:16]; dat = mdl_sh[15:0]; end
        else begin head = mdl_sh[8:0]; dat = '0; end
        if (!head[8]) mdl_bad_start <= mdl_bad_start + 1;
        case (head[7:6])
          2'b01: if (mdl_ew) begin mdl_mem[head[5:0]] <= dat; busy_cnt <= busy_len; end
          2'b11: if (mdl_ew) begin mdl_mem[head[5:0]] <= 16'hFFFF; busy_cnt <= busy_len; end
          2'b00: case (head[5:4])
            2'b11: mdl_ew <= 1'b1;
            2'b00: mdl_ew <= 1'b0;
            2'b10: if (mdl_ew) begin
              for (int i = 0; i < 64; i++) mdl_mem[i] <= 16'hFFFF;
              busy_cnt <= busy_len;
            end
            default: if (mdl_ew) begin
              for (int i = 0; i < 64; i++) mdl_mem[i] <= dat;
              busy_cnt <= busy_len;
            end
          endcase
          default: ;
        endcase
      end
    end
  end

  // ---------------- monitors ----------------
  int hi_run = 0, lo_run = 0, cs_low_run = 0, cs_rises = 0;
  int bad_r2 = 0, bad_r6 = 0, bad_r7 = 0;
  logic di_at_rise = 1'b0, mon_sk = 1'b0, mon_cs = 1'b0;
  bit   seen_cs = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (ee_sk && !ee_cs) bad_r2++;
    if (!ee_cs && ee_di) bad_r6++;
    if (ee_sk && !mon_sk) di_at_rise = ee_di;
    if (ee_sk && mon_sk && ee_di != di_at_rise) bad_r6++;
    if (ee_sk) hi_run++;
    if (!ee_sk && mon_sk) begin if (hi_run != HALF) bad_r2++; hi_run = 0; end
    if (ee_cs && !ee_sk) lo_run++;
    if (ee_sk && !mon_sk) begin if (lo_run != HALF) bad_r2++; lo_run = 0; end
    if (!ee_cs) lo_run = 0;
    if (!ee_cs) cs_low_run++;
    if (ee_cs && !mon_cs) begin
      if (seen_cs && cs_low_run < HALF) bad_r7++;
      seen_cs = 1'b1;
      cs_low_run = 0;
      cs_rises++;
    end
    if (rsp_done && ee_cs) bad_r7++;
    mon_sk = ee_sk;
    mon_cs = ee_cs;
  end

  // ---------------- bench reference ----------------
  logic [15:0] exp_mem [64];
  logic        exp_ew = 1'b0;
  initial for (int i = 0; i < 64; i++) exp_mem[i] = init_word(i);

  function automatic int exp_len(input logic [2:0] op);
    return (op == 3'd0 || op == 3'd1 || op == 3'd6) ? 25 : 9;
  endfunction
  function automatic bit exp_polls(input logic [2:0] op);
    return op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6;
  endfunction

  int ready_bad = 0, pulse_bad = 0;
  logic [15:0] got_rdata;
  logic got_err;

  task automatic do_cmd(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d);
    int waitc;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    cs_rises = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (cmd_ready) ready_bad++;
    waitc = 0;
    while (!rsp_done && waitc < 20000) begin
      @(negedge clk);
      if (cmd_ready && !rsp_done) ready_bad++;
      waitc++;
    end
    if (!cmd_ready) ready_bad++;
    got_rdata = rsp_rdata;
    got_err = rsp_err;
    chk(busy_cnt == 0 || got_err, "R8", "done while device busy", busy_cnt, 0);
    @(negedge clk);
    if (rsp_done) pulse_bad++;
  endtask

  task automatic run(input logic [2:0] op, input logic [5:0] a,
                     input logic [15:0] d, input bit want_err);
    logic [15:0] expv;
    expv = exp_mem[a];
    do_cmd(op, a, d);
    chk(mdl_last_len == exp_len(op), (exp_len(op) == 25) ? "R5" : "R3",
        "frame clocks", mdl_last_len, exp_len(op));
    chk(cs_rises == (exp_polls(op) ? 2 : 1), "R8", "cs high periods",
        cs_rises, exp_polls(op) ? 2 : 1);
    chk(got_err == want_err, want_err ? "R9" : "R8", "rsp_err", got_err, want_err);
    if (op == 3'd0)
      chk(got_rdata == expv, "R4", "read data", got_rdata, expv);
    case (op)
      3'd1: if (exp_ew) exp_mem[a] = d;
      3'd2: if (exp_ew) exp_mem[a] = 16'hFFFF;
      3'd3: exp_ew = 1'b1;
      3'd5: if (exp_ew) for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
      3'd6: if (exp_ew) for (int i = 0; i < 64; i++) exp_mem[i] = d;
      3'd0: ;
      default: exp_ew = 1'b0;
    endcase
  endtask

  bit wd_hit = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    wd_hit = 1'b1;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed_dummy;
    logic [5:0] ra;
    logic [15:0] rd;
    logic [2:0] rop;
    seed_dummy = $urandom(32'h1BAD5EED);
    repeat (3) @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di && !rsp_done && cmd_ready, "R1",
        "outputs in reset", {ee_cs, ee_sk, ee_di, rsp_done, cmd_ready}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di && !rsp_done && cmd_ready, "R1",
        "outputs after reset", {ee_cs, ee_sk, ee_di, rsp_done, cmd_ready}, 5'b00001);

    // writes are refused by the device until enabled (R3 code values)
    run(3'd1, 6'd5, 16'h1234, 1'b0);
    run(3'd0, 6'd5, 16'h0, 1'b0);
    run(3'd3, 6'd0, 16'h0, 1'b0);

    // random mix (R4, R5, R8)
    for (int k = 0; k < 14; k++) begin
      ra = 6'($urandom_range(0, 63));
      rd = 16'($urandom);
      busy_len = $urandom_range(5, 40);
      rop = 3'($urandom_range(0, 2));
      run(rop, ra, rd, 1'b0);
      run(3'd0, ra, 16'h0, 1'b0);
    end

    // corner words
    run(3'd1, 6'd63, 16'h8001, 1'b0);
    run(3'd0, 6'd63, 16'h0, 1'b0);
    run(3'd1, 6'd0, 16'h0000, 1'b0);
    run(3'd0, 6'd0, 16'h0, 1'b0);

    // fill-all and clear-all (R3, R5)
    run(3'd6, 6'd0, 16'hA5C3, 1'b0);
    run(3'd0, 6'd17, 16'h0, 1'b0);
    run(3'd0, 6'd63, 16'h0, 1'b0);
    run(3'd5, 6'd0, 16'h0, 1'b0);
    run(3'd0, 6'd42, 16'h0, 1'b0);

    // write then disable; second write must not land (R3)
    run(3'd1, 6'd9, 16'h0F0F, 1'b0);
    run(3'd7, 6'd0, 16'h0, 1'b0);
    run(3'd1, 6'd9, 16'hBEEF, 1'b0);
    run(3'd0, 6'd9, 16'h0, 1'b0);

    // device stays busy: timeout (R9)
    run(3'd3, 6'd0, 16'h0, 1'b0);
    busy_len = 500;
    run(3'd1, 6'd12, 16'h4321, 1'b1);
    repeat (600) @(negedge clk);
    busy_len = 20;
    run(3'd0, 6'd12, 16'h0, 1'b0);
    run(3'd2, 6'd12, 16'h0, 1'b0);
    chk(!rsp_err, "R9", "error cleared by next command", rsp_err, 0);
    run(3'd0, 6'd12, 16'h0, 1'b0);

    chk(bad_r2 == 0, "R2", "serial clock phase violations", bad_r2, 0);
    chk(bad_r6 == 0, "R6", "data-in violations", bad_r6, 0);
    chk(bad_r7 == 0, "R7", "chip select gap violations", bad_r7, 0);
    chk(ready_bad == 0, "R10", "cmd_ready while busy", ready_bad, 0);
    chk(pulse_bad == 0, "R10", "done longer than one cycle", pulse_bad, 0);
    chk(mdl_bad_start == 0, "R3", "frames without start bit", mdl_bad_start, 0);

    if (!wd_hit) begin
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule